// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Logic Array

This block evaluates a set of Boolean outputs as two-level sum-of-products functions of an input vector. The first level forms product terms: each term is the AND of selected input literals, where every input either appears as itself, appears inverted, or is left out. The second level forms each output as the OR of any chosen subset of those terms. A single term may drive several outputs at once, so logic that is common to several functions is built only once.

The personality of both planes is held in a configuration register. Software or a boot sequencer loads it one bit per clock through a serial port while a configuration-enable pin is high. After reset every connection is present. Every literal is then present in both polarities, which makes each term constant 0 and therefore every output 0. Loading a personality removes the connections that are not wanted.

Evaluation uses a valid/ready stream. An input word is accepted and its result is offered in the same cycle, with no storage in between. Back-pressure passes straight through: `in_ready` follows `out_ready`. While the array is being configured, both `in_ready` and `out_valid` are held low, so no word can be evaluated against a partly loaded personality.

Top module: `sop_logic_array`

## Requirements
- R1: Reset sets every configuration bit to 1. With `cfg_en` low after reset, every accepted input word yields an all-zero `out_data`.
- R2: While `cfg_en` is high, one configuration bit enters per clock from `cfg_bit`, and the first bit sent ends up in the highest position. The word is W = N_TERM*N_IN*2 + N_OUT*N_TERM bits wide. Bit o*N_TERM+t connects term t to output o. The 2-bit literal code for input i of term t sits at bits N_OUT*N_TERM + 2*(t*N_IN+i) and the position above it.
- R3: While `cfg_en` is low, changes on `cfg_bit` have no effect on the stored personality or on the outputs.
- R4: Literal code 00 leaves the input out of the term. Code 01 uses `in_data[i]` as it is. Code 10 uses the inverse of `in_data[i]`.
- R5: Literal code 11 forces its product term to 0 for every input value.
- R6: A product term whose literals all have code 00 evaluates to 1.
- R7: Each output is the OR of the terms connected to it. An output with no connected term is 0.
- R8: One term may feed several outputs. Take three inputs A=`in_data[0]`, B=`in_data[1]`, C=`in_data[2]`, five terms AB, B'C, AC', B'C', A, and four outputs. Programmed this way, the block yields F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A for all eight input values.
- R9: With `cfg_en` low, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. With `cfg_en` high, both `out_valid` and `in_ready` are 0.
- R10: `out_data` is a combinational function of `in_data` and the stored personality, valid in the same cycle as `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | N_IN | Input variables |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | N_OUT | Sum-of-products results |

## Verification
Two functions can fall in the same cycle: configuration shifting and an evaluation request. The bench keeps `in_valid` high through a whole personality load. Every cycle of that load, it checks that `out_valid` and `in_ready` stay low and that no result reaches the scoreboard. Once `cfg_en` drops, the first accepted word must match the newly loaded equations and not any partial state. A separate run holds `out_ready` low to confirm that back-pressure blocks acceptance without changing the result presented.

// File: rtl/sla_pkg.sv
package sla_pkg;

  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_INV  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // Contribution of one literal to a product term.
  function automatic logic lit_pass(input lit_code_e code, input logic x);
    case (code)
      LIT_OFF:  lit_pass = 1'b1;
      LIT_TRUE: lit_pass = x;
      LIT_INV:  lit_pass = ~x;
      default:  lit_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sla_cfg_shift.sv
module sla_cfg_shift #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '1;
    else if (shift_en) word <= {word[W-2:0], shift_bit};
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word)); // R3

  AST_CFG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(shift_bit))); // R2

endmodule

// File: rtl/sla_and_plane.sv
module sla_and_plane
  import sla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_IN-1:0]            in_vec,
  input  logic [N_TERM*N_IN*2-1:0]   codes,
  output logic [N_TERM-1:0]          term_vec
);

  localparam int TERM_BITS = N_IN * 2;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] pass;
    logic [N_IN-1:0] is_kill;
    logic [N_IN-1:0] is_off;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      lit_code_e code;
      assign code       = lit_code_e'(codes[t*TERM_BITS + 2*i +: 2]);
      assign pass[i]    = lit_pass(code, in_vec[i]);
      assign is_kill[i] = (codes[t*TERM_BITS + 2*i +: 2] == 2'b11);
      assign is_off[i]  = (codes[t*TERM_BITS + 2*i +: 2] == 2'b00);
    end

    assign term_vec[t] = &pass;

    AST_KILL_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (|is_kill) |-> !term_vec[t]); // R5

    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (&is_off) |-> term_vec[t]); // R6
  end

endmodule

// File: rtl/sla_or_plane.sv
module sla_or_plane #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TERM-1:0]         term_vec,
  input  logic [N_OUT*N_TERM-1:0]   conn,
  output logic [N_OUT-1:0]          out_vec
);

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] sel;
    assign sel        = conn[o*N_TERM +: N_TERM];
    assign out_vec[o] = |(sel & term_vec);

    AST_UNCONNECTED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !out_vec[o]); // R7
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_IN-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N_OUT-1:0] out_data
);

  localparam int OR_W  = N_OUT * N_TERM;
  localparam int AND_W = N_TERM * N_IN * 2;
  localparam int CFG_W = AND_W + OR_W;

  logic [CFG_W-1:0]  cfg_word;
  logic [N_TERM-1:0] terms;

  sla_cfg_shift #(.W(CFG_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .shift_bit(cfg_bit),
    .word     (cfg_word)
  );

  sla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) i_and (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vec  (in_data),
    .codes   (cfg_word[CFG_W-1:OR_W]),
    .term_vec(terms)
  );

  sla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) i_or (
    .clk     (clk),
    .rst_n   (rst_n),
    .term_vec(terms),
    .conn    (cfg_word[OR_W-1:0]),
    .out_vec (out_data)
  );

  assign out_valid = in_valid & ~cfg_en;
  assign in_ready  = out_ready & ~cfg_en;

  AST_CFG_BLOCKS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (!out_valid && !in_ready)); // R9

  AST_ACCEPT_IS_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready)); // R9

  AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data != '0) |-> (terms != '0)); // R7

endmodule

// File: tb/test_sop_logic_array.sv
module test_sop_logic_array;

  localparam int N_IN   = 3;
  localparam int N_TERM = 5;
  localparam int N_OUT  = 4;
  localparam int OR_W   = N_OUT * N_TERM;
  localparam int CFG_W  = N_TERM * N_IN * 2 + OR_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_en = 1'b0;
  logic             cfg_bit = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [N_IN-1:0]  in_data = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [N_OUT-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [N_OUT-1:0] exp_q[$];
  string            tag_q[$];

  always #2 clk = ~clk;

  sop_logic_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_sop_logic_array (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: stream rules every cycle, scoreboard pop on each transfer.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cfg_en)
        check(!out_valid && !in_ready, "R9 stream closed during cfg",
              {out_valid, in_ready}, 0);
      else
        check(in_ready == out_ready && out_valid == in_valid, "R9 passthrough",
              {out_valid, in_ready}, {in_valid, out_ready});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R9 unexpected result", out_data, 0);
        else begin
          automatic logic [N_OUT-1:0] e = exp_q.pop_front();
          automatic string tg = tag_q.pop_front();
          check(out_data == e, tg, out_data, e);
        end
      end
    end
  end

  function automatic int and_pos(input int t, input int i);
    return OR_W + 2 * (t * N_IN + i);
  endfunction

  function automatic logic [N_OUT-1:0] ref_eval(input logic [2:0] x);
    logic a, b, c;
    a = x[0]; b = x[1]; c = x[2];
    ref_eval[0] = a | (~b & ~c);
    ref_eval[1] = (a & ~c) | (a & b);
    ref_eval[2] = (~b & ~c) | (a & b);
    ref_eval[3] = (~b & c) | a;
  endfunction

  task automatic send(input logic [N_IN-1:0] x, input logic [N_OUT-1:0] e, input string tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    in_valid = 1'b1;
    in_data  = x;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [CFG_W-1:0] w);
    for (int b = CFG_W - 1; b >= 0; b--) begin
      cfg_en  = 1'b1;
      cfg_bit = w[b];
      @(posedge clk); #1;
    end
    cfg_en = 1'b0;
  endtask

  initial begin
    logic [CFG_W-1:0] w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset personality gives all-zero outputs
    for (int x = 0; x < 8; x++) send(x[2:0], '0, "R1 reset outputs zero");

    // R8/R2/R4/R7: reference personality, terms AB, B'C, AC', B'C', A
    w = '0;
    w[and_pos(0,0) +: 2] = 2'b01; w[and_pos(0,1) +: 2] = 2'b01;
    w[and_pos(1,1) +: 2] = 2'b10; w[and_pos(1,2) +: 2] = 2'b01;
    w[and_pos(2,0) +: 2] = 2'b01; w[and_pos(2,2) +: 2] = 2'b10;
    w[and_pos(3,1) +: 2] = 2'b10; w[and_pos(3,2) +: 2] = 2'b10;
    w[and_pos(4,0) +: 2] = 2'b01;
    w[0*N_TERM + 4] = 1'b1; w[0*N_TERM + 3] = 1'b1;
    w[1*N_TERM + 2] = 1'b1; w[1*N_TERM + 0] = 1'b1;
    w[2*N_TERM + 3] = 1'b1; w[2*N_TERM + 0] = 1'b1;
    w[3*N_TERM + 1] = 1'b1; w[3*N_TERM + 4] = 1'b1;
    in_valid = 1'b1;  // R9 collision: request held through the load
    in_data  = 3'b101;
    load(w);
    in_valid = 1'b0;
    for (int x = 0; x < 8; x++) send(x[2:0], ref_eval(x[2:0]), "R8 reference equations");

    // R3: cfg_bit toggling with cfg_en low changes nothing
    for (int k = 0; k < 60; k++) begin
      cfg_bit = k[0];
      @(posedge clk); #1;
    end
    for (int x = 0; x < 8; x++) send(x[2:0], ref_eval(x[2:0]), "R3 personality held");

    // R9: back-pressure blocks acceptance, result still presented
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 3'b010;
    @(negedge clk);
    check(in_ready == 1'b0, "R9 back-pressure in_ready", in_ready, 0);
    check(out_data == ref_eval(3'b010), "R10 combinational result", out_data, ref_eval(3'b010));
    @(posedge clk); #1;
    in_valid  = 1'b0;
    out_ready = 1'b1;

    // R5/R6/R7/R4: kill code, empty term, unconnected output, mixed literals
    w = '0;
    w[and_pos(0,0) +: 2] = 2'b11;  // term0 killed
    w[and_pos(2,0) +: 2] = 2'b01;  // term2 = A & C'
    w[and_pos(2,2) +: 2] = 2'b10;
    w[0*N_TERM + 0] = 1'b1;        // out0 <- killed term
    w[1*N_TERM + 1] = 1'b1;        // out1 <- empty term
    w[3*N_TERM + 2] = 1'b1;        // out3 <- A & C'
    load(w);
    for (int x = 0; x < 8; x++) begin
      automatic logic [N_OUT-1:0] e;
      e = {x[0] & ~x[2], 1'b0, 1'b1, 1'b0};
      send(x[2:0], e, "R5 R6 R7 R4 special codes");
    end

    @(posedge clk); #1;
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule